// File: doc/BRIEF.md
# Four-Level Symbol Phase Demultiplexer

This block takes a stream of bit-centre symbols, each a value from 0 to 3, and turns them into bits on four parallel phase lanes, A to D. It handles two-level and four-level signalling at a single rate (1600 baud) and at a double rate (3200 baud). At the double rate, consecutive symbols are interleaved: the first symbol of each pair fills the A/B lanes and the second fills the C/D lanes.

The block produces one registered 4-bit word for each completed output slot, together with a one-cycle valid strobe. A slot is one symbol at the single rate and one pair of symbols at the double rate. Lanes that the current mode does not use stay at zero, and zero stands for idle code.

Two control inputs come from the surrounding frame logic. One marks the start of a frame and realigns the interleave. The other returns the block to idle and clears all of its state. Frame timing and codeword deinterleaving are left to the neighbouring blocks.

Top module: `sym_phase_demux`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it rises, `wordValid` is 0 and `phaseWord` is 0.
- R2: The first bit of a pair (lane A for the first symbol of a slot, lane C for the second) is 1 for symbols 0 and 1, and 0 for symbols 2 and 3.
- R3: With `fourLevel` high, the second bit of a pair (lane B or lane D) is 1 for symbols 0 and 3, and 0 for symbols 1 and 2. This is a Gray mapping.
- R4: With `fourLevel` low, lanes B and D are never written, so after an idle clear they read 0 in every emitted word.
- R5: With `rateDouble` low, every accepted symbol emits one word on the next cycle. Bit 0 of the word is lane A and bit 1 is lane B. Lanes C (bit 2) and D (bit 3) are not written, so after an idle clear they read 0.
- R6: With `rateDouble` high, the first accepted symbol of a pair writes lanes A/B and emits nothing. The second writes lanes C/D and emits the word holding all four lanes.
- R7: A cycle with `symValid` low changes no state, and `phaseWord` holds its value in every cycle in which `wordValid` is low.
- R8: `frameIdle` high clears all four lanes, the interleave toggle and `phaseWord`. A symbol offered in the same cycle is dropped and gives no strobe.
- R9: `frameStart` high clears the interleave toggle, so the symbol accepted in that cycle, or the next symbol accepted after it, goes to the A/B lanes.
- R10: `wordValid` is high for exactly one cycle per emitted word. It rises the cycle after the accepting edge, and `phaseWord` carries that word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rateDouble | input | 1 | 1 selects the double rate (3200 baud, pair interleave); 0 selects 1600 baud |
| fourLevel | input | 1 | 1 selects four-level signalling; 0 selects two-level |
| frameStart | input | 1 | Start of frame: clears the interleave toggle |
| frameIdle | input | 1 | Return to idle: clears lanes, toggle and output word |
| symValid | input | 1 | `symIn` holds a bit-centre symbol this cycle |
| symIn | input | 2 | Symbol value, 0 to 3 |
| wordValid | output | 1 | One-cycle strobe per emitted word |
| phaseWord | output | 4 | Lanes {D,C,B,A}, with A in bit 0 |

## Verification
Two pairs of functions can land on the same edge. The first pair is the idle clear and symbol acceptance. The second is the frame-start toggle reset and symbol acceptance, which matters most when it arrives halfway through a double-rate pair.

The bench raises `frameIdle` or `frameStart` together with `symValid`, both after an odd number of double-rate symbols and at the single rate. It then checks that:
- the idle case produces no strobe and a zero word;
- the start case places the symbol on A/B and emits nothing until a second symbol arrives.

Every symbol value and every ordered symbol pair is swept in all four mode combinations, and each result is compared with a word the bench builds from the lane rules.

// File: rtl/sym_phase_pkg.sv
package sym_phase_pkg;

  localparam int SYM_W     = 2;
  localparam int PAIRS     = 2;
  localparam int LANES     = 2 * PAIRS;
  localparam int PAIR_IDXW = (PAIRS > 1) ? $clog2(PAIRS) : 1;

  // Strobes that the control half hands to the datapath each cycle
  typedef struct packed {
    logic             clrAll;   // return to idle: wipe lanes and output
    logic [PAIRS-1:0] loadPair; // which lane pair takes the current symbol
    logic             wrLo;     // also write the second bit of the pair
    logic             emit;     // present the assembled word this edge
  } ctrlStrobes_t;

  // First bit of a pair: set for the two lower symbol values
  function automatic logic hiBitOf(input logic [SYM_W-1:0] s);
    return (s < 2);
  endfunction

  // Second bit of a pair: Gray-style, set for the outer values 0 and 3
  function automatic logic loBitOf(input logic [SYM_W-1:0] s);
    return (s == 2'd0) || (s == 2'd3);
  endfunction

endpackage

// File: rtl/sym_phase_ctrl.sv
module sym_phase_ctrl
  import sym_phase_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         rateDouble,
  input  logic         fourLevel,
  input  logic         frameStart,
  input  logic         frameIdle,
  input  logic         symValid,
  output ctrlStrobes_t strobes
);

  logic pairToggle;     // 1: next symbol goes to the second pair
  logic toggleEff;      // toggle as seen this cycle after a start clear
  logic accept;
  logic [PAIR_IDXW-1:0] pairSel;
  logic toggleNext;

  assign accept    = symValid && !frameIdle;
  assign toggleEff = frameStart ? 1'b0 : pairToggle;
  assign pairSel   = rateDouble ? PAIR_IDXW'(toggleEff) : '0;

  always_comb begin
    strobes          = '0;
    strobes.clrAll   = frameIdle;
    strobes.wrLo     = fourLevel;
    for (int p = 0; p < PAIRS; p++) begin
      strobes.loadPair[p] = accept && (pairSel == PAIR_IDXW'(p));
    end
    strobes.emit     = accept && (!rateDouble || toggleEff);
  end

  always_comb begin
    toggleNext = toggleEff;
    if (frameIdle) begin
      toggleNext = 1'b0;
    end else if (accept) begin
      toggleNext = rateDouble ? !toggleEff : 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pairToggle <= 1'b0;
    end else begin
      pairToggle <= toggleNext;
    end
  end

endmodule

// File: rtl/sym_phase_dp.sv
module sym_phase_dp
  import sym_phase_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobes_t     strobes,
  input  logic [SYM_W-1:0] symIn,
  output logic             wordValid,
  output logic [LANES-1:0] phaseWord
);

  logic symHi;
  logic symLo;
  logic [LANES-1:0] laneReg;
  logic [LANES-1:0] laneNext;

  assign symHi = hiBitOf(symIn);
  assign symLo = loBitOf(symIn);

  // One register pair per lane pair; even lane = first bit, odd = second
  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    always_comb begin
      laneNext[2*p]   = laneReg[2*p];
      laneNext[2*p+1] = laneReg[2*p+1];
      if (strobes.loadPair[p]) begin
        laneNext[2*p] = symHi;
        if (strobes.wrLo) begin
          laneNext[2*p+1] = symLo;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN || strobes.clrAll) begin
        laneReg[2*p]   <= 1'b0;
        laneReg[2*p+1] <= 1'b0;
      end else begin
        laneReg[2*p]   <= laneNext[2*p];
        laneReg[2*p+1] <= laneNext[2*p+1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobes.clrAll) begin
      wordValid <= 1'b0;
      phaseWord <= '0;
    end else begin
      wordValid <= strobes.emit;
      if (strobes.emit) begin
        phaseWord <= laneNext;
      end
    end
  end

endmodule

// File: rtl/sym_phase_demux.sv
module sym_phase_demux
  import sym_phase_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       rateDouble,
  input  logic       fourLevel,
  input  logic       frameStart,
  input  logic       frameIdle,
  input  logic       symValid,
  input  logic [1:0] symIn,
  output logic       wordValid,
  output logic [3:0] phaseWord
);

  ctrlStrobes_t strobes;

  sym_phase_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .rateDouble (rateDouble),
    .fourLevel  (fourLevel),
    .frameStart (frameStart),
    .frameIdle  (frameIdle),
    .symValid   (symValid),
    .strobes    (strobes)
  );

  sym_phase_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .symIn     (symIn),
    .wordValid (wordValid),
    .phaseWord (phaseWord)
  );

endmodule

// File: rtl/sym_phase_demux_chk.sv
module sym_phase_demux_chk (
  input logic       clk,
  input logic       rstN,
  input logic       rateDouble,
  input logic       fourLevel,
  input logic       frameStart,
  input logic       frameIdle,
  input logic       symValid,
  input logic [1:0] symIn,
  input logic       wordValid,
  input logic [3:0] phaseWord
);

  // R10
  strobe_has_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> $past(symValid && !frameIdle));

  // R8
  idle_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    frameIdle |=> (!wordValid && phaseWord == 4'd0));

  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!wordValid && !$past(frameIdle)) |-> $stable(phaseWord));

  // R5
  single_rate_emit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && !frameIdle && !rateDouble) |=> wordValid);

  // R2
  first_bit_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && !frameIdle && !rateDouble) |=> (phaseWord[0] == ($past(symIn) <= 2'd1)));

  // R3
  gray_bit_map_chk: assert property (@(posedge clk) disable iff (!rstN)
    (symValid && !frameIdle && !rateDouble && fourLevel)
      |=> (phaseWord[1] == ($past(symIn[1]) == $past(symIn[0]))));

  // R1
  reset_state_chk: assert property (@(posedge clk)
    $rose(rstN) |-> (!wordValid && phaseWord == 4'd0));

endmodule

bind sym_phase_demux sym_phase_demux_chk u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .rateDouble (rateDouble),
  .fourLevel  (fourLevel),
  .frameStart (frameStart),
  .frameIdle  (frameIdle),
  .symValid   (symValid),
  .symIn      (symIn),
  .wordValid  (wordValid),
  .phaseWord  (phaseWord)
);

// File: tb/tb_sym_phase_demux.sv
`timescale 1ns/1ps
module tb_sym_phase_demux;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       rateDouble = 1'b0;
  logic       fourLevel = 1'b0;
  logic       frameStart = 1'b0;
  logic       frameIdle = 1'b0;
  logic       symValid = 1'b0;
  logic [1:0] symIn = 2'd0;
  logic       wordValid;
  logic [3:0] phaseWord;

  int vecCount = 0;
  int missCount = 0;
  bit finished = 1'b0;

  // Expected-state model built from the lane rules
  logic mA = 0, mB = 0, mC = 0, mD = 0, mTog = 0;
  logic expValid = 0;
  logic [3:0] expWord = 4'd0;

  always #2 clk = ~clk;   // 250 MHz

  sym_phase_demux dut (
    .clk(clk), .rstN(rstN), .rateDouble(rateDouble), .fourLevel(fourLevel),
    .frameStart(frameStart), .frameIdle(frameIdle), .symValid(symValid),
    .symIn(symIn), .wordValid(wordValid), .phaseWord(phaseWord)
  );

  task automatic check(input string req, input logic gotV, input logic [3:0] gotW,
                       input logic wantV, input logic [3:0] wantW);
    vecCount++;
    if (gotV !== wantV || gotW !== wantW) begin
      missCount++;
      $display("FAIL %s: valid=%0b word=%b expected valid=%0b word=%b",
               req, gotV, gotW, wantV, wantW);
    end
  endtask

  // Advance the model by one edge with the given inputs
  task automatic modelStep(input logic sv, input logic [1:0] s, input logic st,
                           input logic idl);
    logic first, second, togE, emit;
    first  = (s[1] == 1'b0);          // values 0,1
    second = (s[1] ~^ s[0]);          // values 0,3
    emit   = 1'b0;
    if (idl) begin
      {mA, mB, mC, mD, mTog} = '0;
      expValid = 1'b0;
      expWord  = 4'd0;
    end else begin
      togE = st ? 1'b0 : mTog;
      mTog = togE;
      if (sv) begin
        if (!rateDouble || !togE) begin
          mA = first;
          if (fourLevel) mB = second;
          mTog = rateDouble;
          emit = !rateDouble;
        end else begin
          mC = first;
          if (fourLevel) mD = second;
          mTog = 1'b0;
          emit = 1'b1;
        end
      end
      expValid = emit;
      if (emit) expWord = {mD, mC, mB, mA};
    end
  endtask

  // Drive one cycle at the falling edge, sample 1 ns after the rising edge
  task automatic step(input string req, input logic sv, input logic [1:0] s,
                      input logic st, input logic idl);
    @(negedge clk);
    symValid = sv; symIn = s; frameStart = st; frameIdle = idl;
    @(posedge clk);
    #1;
    modelStep(sv, s, st, idl);
    check(req, wordValid, phaseWord, expValid, expWord);
    symValid = 1'b0; frameStart = 1'b0; frameIdle = 1'b0;
  endtask

  task automatic setMode(input logic dbl, input logic lvl4);
    @(negedge clk);
    rateDouble = dbl; fourLevel = lvl4;
  endtask

  initial begin
    // R1: reset state
    repeat (3) @(posedge clk);
    #1 check("R1", wordValid, phaseWord, 1'b0, 4'd0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1 check("R1", wordValid, phaseWord, 1'b0, 4'd0);

    for (int m = 0; m < 4; m++) begin
      setMode(m[1], m[0]);
      step("R8", 1'b0, 2'd0, 1'b0, 1'b1);
      step("R9", 1'b0, 2'd0, 1'b1, 1'b0);
      if (m[1] == 1'b0) begin
        // R2 R3 R4 R5 single rate sweep of every symbol
        for (int s = 0; s < 4; s++) begin
          step(m[0] ? "R3" : "R4", 1'b1, s[1:0], 1'b0, 1'b0);
          step("R7", 1'b0, 2'd3, 1'b0, 1'b0);
        end
        for (int s = 0; s < 4; s++) step("R5", 1'b1, s[1:0], 1'b0, 1'b0);
      end else begin
        // R6: every ordered pair, with a gap inside the pair
        for (int a = 0; a < 4; a++) begin
          for (int b = 0; b < 4; b++) begin
            step("R6", 1'b1, a[1:0], 1'b0, 1'b0);
            step("R7", 1'b0, b[1:0], 1'b0, 1'b0);
            step(m[0] ? "R2" : "R4", 1'b1, b[1:0], 1'b0, 1'b0);
            step("R10", 1'b0, 2'd0, 1'b0, 1'b0);
          end
        end
        // R9: start arrives after an odd symbol, together with a symbol
        step("R6", 1'b1, 2'd2, 1'b0, 1'b0);
        step("R9", 1'b1, 2'd1, 1'b1, 1'b0);
        step("R9", 1'b1, 2'd3, 1'b0, 1'b0);
        // R9: start alone mid-pair, next symbol goes to A/B
        step("R6", 1'b1, 2'd0, 1'b0, 1'b0);
        step("R9", 1'b0, 2'd0, 1'b1, 1'b0);
        step("R9", 1'b1, 2'd2, 1'b0, 1'b0);
        step("R9", 1'b1, 2'd0, 1'b0, 1'b0);
        // R8: idle together with the completing symbol of a pair
        step("R6", 1'b1, 2'd0, 1'b0, 1'b0);
        step("R8", 1'b1, 2'd3, 1'b0, 1'b1);
        step("R8", 1'b1, 2'd1, 1'b0, 1'b0);
        step("R8", 1'b1, 2'd0, 1'b0, 1'b0);
      end
      // R8: idle with a symbol at any rate
      step("R8", 1'b1, 2'd0, 1'b0, 1'b1);
      step("R8", 1'b0, 2'd0, 1'b0, 1'b0);
    end

    // R4: two-level after four-level frame, B/D must read 0
    setMode(1'b1, 1'b1);
    step("R6", 1'b1, 2'd0, 1'b0, 1'b0);
    step("R6", 1'b1, 2'd3, 1'b0, 1'b0);
    step("R8", 1'b0, 2'd0, 1'b0, 1'b1);
    setMode(1'b1, 1'b0);
    step("R4", 1'b1, 2'd0, 1'b1, 1'b0);
    step("R4", 1'b1, 2'd3, 1'b0, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!finished) begin
      vecCount++;
      missCount++;
      $display("FAIL watchdog: valid=%0b word=%b expected valid=x word=x (run hung)",
               wordValid, phaseWord);
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

endmodule